// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches page table entries so that a 32-bit virtual address can be turned into a physical address without a memory access. Pages are 4 KB. The low 12 address bits pass straight through. The upper bits form the virtual page number, which is compared at the same time against the tag of every valid slot. There is no index, so an entry may occupy any slot.

A lookup is resolved combinationally in the cycle it is presented. It raises exactly one of three outcomes: hit, miss or fault. On a miss, an external handler fetches the entry and installs it through the refill port, then repeats the access. Each slot keeps a usage flag and a modified flag. A hit sets the usage flag, and a write hit also sets the modified flag. A single clear command drops every usage flag at once, so that software can age the slots. A refill chooses its slot in this order: a slot that already holds the same page, then an empty slot, then a slot whose usage flag is clear, and finally the slot named by a rotating pointer.

Top module: `tlb_fa`

## Requirements
- R1: On a hit, `lk_paddr` is the stored physical page number in bits 31:12 followed by `lk_vaddr[11:0]` unchanged in bits 11:0, in the same cycle as the lookup.
- R2: With `lk_valid` high, exactly one of `lk_hit`, `lk_miss`, `lk_fault` is 1. A lookup whose page matches no valid slot gives `lk_miss`. With `lk_valid` low, all three are 0. `lk_paddr`, `lk_ref` and `lk_dirty` are 0 when there is no hit or fault.
- R3: A lookup that matches a slot installed with `fill_present`=0 raises `lk_fault`, not `lk_hit`, and drives `lk_paddr` to 0.
- R4: After reset every slot is empty, so every lookup misses.
- R5: `lk_ref` and `lk_dirty` report the matched slot's flags as they stood before the current access. A hit sets that slot's usage flag from the next cycle on.
- R6: A hit with `lk_write`=1 sets the slot's modified flag. A read hit leaves it unchanged.
- R7: `clr_ref` clears the usage flag of every slot. A hit in the same cycle still sets its own slot's flag.
- R8: A refill marks its slot valid, sets its usage flag to 1 and clears its modified flag. A refill of a page that is already held overwrites that slot, so a page never occupies two slots.
- R9: A refill of a new page takes the lowest-numbered empty slot when one exists.
- R10: With no empty slot, a refill takes the lowest-numbered slot whose usage flag is 0.
- R11: With every usage flag set, a refill takes the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one each time it is used.
- R12: A lookup that faults changes neither the usage flag nor the modified flag of its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_write | input | 1 | The lookup is a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found and page present |
| lk_miss | output | 1 | No slot holds the page |
| lk_fault | output | 1 | Slot found but page marked not present |
| lk_paddr | output | 32 | Translated physical address (0 unless hit) |
| lk_ref | output | 1 | Usage flag of the matched slot before this access |
| lk_dirty | output | 1 | Modified flag of the matched slot before this access |
| fill_en | input | 1 | Install an entry this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_present | input | 1 | Page is resident in memory |
| clr_ref | input | 1 | Clear every usage flag |

## Verification
The assertions assume that the refill port is the only way tags enter the array, and that `lk_write` is meaningful only while `lk_valid` is high. The duplicate-freedom check relies on this: the refill path's own tag comparison removes any repeat. The stimulus never drives a refill and a hit to the same slot in one cycle except through the overwrite path that R8 defines. All inputs change only on falling edges, so the combinational outcomes settle before they are sampled. The replacement sequence fills the array completely before it exercises the usage-flag and pointer choices, so each slot's flags are known at every refill.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

   // Why a refill slot was chosen; only the rotate choice moves the pointer.
   typedef enum logic [1:0] {
      PICK_FREE   = 2'd0,
      PICK_COLD   = 2'd1,
      PICK_ROTATE = 2'd2
   } pick_e;

endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
   parameter int N     = 16,
   parameter int KEY_W = 20,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [KEY_W-1:0]        key,
   input  logic [N-1:0][KEY_W-1:0] tags,
   input  logic [N-1:0]            live,
   output logic [N-1:0]            hits,
   output logic                    any,
   output logic [IDX_W-1:0]        idx
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hits[g] = live[g] && (tags[g] == key);
   end

   assign any = |hits;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/tlb_fa_victim.sv
module tlb_fa_victim
   import tlb_fa_pkg::*;
#(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     vld,
   input  logic [N-1:0]     used,
   input  logic [IDX_W-1:0] rot,
   output logic [IDX_W-1:0] victim,
   output pick_e            pick
);

   logic [IDX_W-1:0] free_idx, cold_idx;
   logic             have_free, have_cold;

   always_comb begin
      free_idx  = '0;
      cold_idx  = '0;
      have_free = 1'b0;
      have_cold = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            free_idx  = IDX_W'(i);
            have_free = 1'b1;
         end
         if (!used[i]) begin
            cold_idx  = IDX_W'(i);
            have_cold = 1'b1;
         end
      end
      if (have_free) begin
         victim = free_idx;
         pick   = PICK_FREE;
      end else if (have_cold) begin
         victim = cold_idx;
         pick   = PICK_COLD;
      end else begin
         victim = rot;
         pick   = PICK_ROTATE;
      end
   end

   AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pick == PICK_FREE) |-> !vld[victim]);                        // R9
   AST_COLD_IS_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (pick == PICK_COLD) |-> (!used[victim] && (&vld)));           // R10
   AST_ROTATE_ALL_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      (pick == PICK_ROTATE) |-> ((&vld) && (&used)));               // R11

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_fa_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int PAGE_W  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lk_valid,
   input  logic                 lk_write,
   input  logic [VA_W-1:0]      lk_vaddr,
   output logic                 lk_hit,
   output logic                 lk_miss,
   output logic                 lk_fault,
   output logic [PA_W-1:0]      lk_paddr,
   output logic                 lk_ref,
   output logic                 lk_dirty,
   input  logic                 fill_en,
   input  logic [VA_W-PAGE_W-1:0] fill_vpn,
   input  logic [PA_W-PAGE_W-1:0] fill_ppn,
   input  logic                 fill_present,
   input  logic                 clr_ref
);

   localparam int VPN_W = VA_W - PAGE_W;
   localparam int PPN_W = PA_W - PAGE_W;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 16 || ENTRIES > 512 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must be a power of two between 16 and 512");
   end
   if (PAGE_W < 1 || VPN_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlb_fa: page offset must leave room for page numbers");
   end

   // slot state
   logic [ENTRIES-1:0][VPN_W-1:0] tags;
   logic [ENTRIES-1:0][PPN_W-1:0] ppns;
   logic [ENTRIES-1:0]            vld, pres, refb, drt;
   logic [IDX_W-1:0]              rot_q;

   // lookup side
   logic [ENTRIES-1:0] lk_match;
   logic               lk_any;
   logic [IDX_W-1:0]   lk_idx;

   tlb_fa_match #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
      .key  (lk_vaddr[VA_W-1:PAGE_W]),
      .tags (tags),
      .live (vld),
      .hits (lk_match),
      .any  (lk_any),
      .idx  (lk_idx)
   );

   logic found;
   assign found    = lk_valid && lk_any;
   assign lk_hit   = found && pres[lk_idx];
   assign lk_fault = found && !pres[lk_idx];
   assign lk_miss  = lk_valid && !lk_any;
   assign lk_paddr = lk_hit ? {ppns[lk_idx], lk_vaddr[PAGE_W-1:0]} : '0;
   assign lk_ref   = found && refb[lk_idx];
   assign lk_dirty = found && drt[lk_idx];

   // refill side: same page first, then the replacement choice
   logic [ENTRIES-1:0] fl_match;
   logic               fl_any;
   logic [IDX_W-1:0]   fl_idx, vic_idx, wr_idx;
   pick_e              vic_pick;

   tlb_fa_match #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_fl_match (
      .key  (fill_vpn),
      .tags (tags),
      .live (vld),
      .hits (fl_match),
      .any  (fl_any),
      .idx  (fl_idx)
   );

   tlb_fa_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (vld),
      .used   (refb),
      .rot    (rot_q),
      .victim (vic_idx),
      .pick   (vic_pick)
   );

   assign wr_idx = fl_any ? fl_idx : vic_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tags  <= '0;
         ppns  <= '0;
         vld   <= '0;
         pres  <= '0;
         refb  <= '0;
         drt   <= '0;
         rot_q <= '0;
      end else begin
         if (clr_ref) refb <= '0;
         if (lk_hit) begin
            refb[lk_idx] <= 1'b1;
            if (lk_write) drt[lk_idx] <= 1'b1;
         end
         if (fill_en) begin
            tags[wr_idx] <= fill_vpn;
            ppns[wr_idx] <= fill_ppn;
            vld[wr_idx]  <= 1'b1;
            pres[wr_idx] <= fill_present;
            refb[wr_idx] <= 1'b1;
            drt[wr_idx]  <= 1'b0;
            if (!fl_any && vic_pick == PICK_ROTATE) rot_q <= rot_q + 1'b1;
         end
      end
   end

   // checks beside the logic they guard
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));              // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));                 // R2
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[PAGE_W-1:0] == lk_vaddr[PAGE_W-1:0]));      // R1
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> (lk_paddr == '0));                                  // R3
   AST_NO_DUP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));                                             // R8
   AST_REF_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !(fill_en && wr_idx == lk_idx)) |=> refb[$past(lk_idx)]); // R5
   AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write && !(fill_en && wr_idx == lk_idx)) |=> drt[$past(lk_idx)]); // R6
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ref && !lk_hit && !fill_en) |=> (refb == '0));              // R7
   AST_FAULT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_fault && !fill_en && !clr_ref) |=>
      (refb[$past(lk_idx)] == $past(refb[lk_idx]) && drt[$past(lk_idx)] == $past(drt[lk_idx]))); // R12
   AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld[$past(wr_idx)] && tags[$past(wr_idx)] == $past(fill_vpn)
                   && refb[$past(wr_idx)] && !drt[$past(wr_idx)]));      // R8

endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_write = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_hit, lk_miss, lk_fault, lk_ref, lk_dirty;
   logic [31:0] lk_paddr;
   logic        fill_en = 1'b0, fill_present = 1'b0, clr_ref = 1'b0;
   logic [19:0] fill_vpn = '0, fill_ppn = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tlb_fa dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
      .lk_paddr(lk_paddr), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_present(fill_present), .clr_ref(clr_ref)
   );

   // vector: op(2) wr(1) addr(32) ppn(20) present(1) req(4) hmf(3) paddr(32) ref(1) dirty(1)
   localparam int VW = 97;
   localparam int NV = 17;
   localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_CLR = 2'd2;

   function automatic logic [VW-1:0] vec(input logic [1:0] op, input logic wr,
      input logic [31:0] a, input logic [19:0] p, input logic pr, input logic [3:0] rq,
      input logic [2:0] hmf, input logic [31:0] epa, input logic er, input logic ed);
      return {op, wr, a, p, pr, rq, hmf, epa, er, ed};
   endfunction

   localparam logic [VW-1:0] TBL [NV] = '{
      vec(OP_LOOK,0,32'h12345678,20'h0,0,4'd4,3'b010,32'h0,0,0),          // R4
      vec(OP_FILL,0,32'h12345000,20'hABCDE,1,4'd0,3'b000,32'h0,0,0),
      vec(OP_LOOK,0,32'h12345678,20'h0,0,4'd1,3'b100,32'hABCDE678,1,0),   // R1
      vec(OP_LOOK,1,32'h12345ABC,20'h0,0,4'd5,3'b100,32'hABCDEABC,1,0),   // R5
      vec(OP_LOOK,0,32'h12345000,20'h0,0,4'd6,3'b100,32'hABCDE000,1,1),   // R6
      vec(OP_CLR, 0,32'h0,20'h0,0,4'd0,3'b000,32'h0,0,0),
      vec(OP_LOOK,0,32'h12345FFF,20'h0,0,4'd7,3'b100,32'hABCDEFFF,0,1),   // R7
      vec(OP_LOOK,0,32'h12345001,20'h0,0,4'd5,3'b100,32'hABCDE001,1,1),   // R5
      vec(OP_FILL,0,32'h00777000,20'h00042,0,4'd0,3'b000,32'h0,0,0),
      vec(OP_CLR, 0,32'h0,20'h0,0,4'd0,3'b000,32'h0,0,0),
      vec(OP_LOOK,1,32'h00777123,20'h0,0,4'd3,3'b001,32'h0,0,0),          // R3
      vec(OP_LOOK,0,32'h00777456,20'h0,0,4'd12,3'b001,32'h0,0,0),         // R12
      vec(OP_FILL,0,32'h12345000,20'h55555,1,4'd0,3'b000,32'h0,0,0),
      vec(OP_LOOK,0,32'h12345234,20'h0,0,4'd8,3'b100,32'h55555234,1,0),   // R8
      vec(OP_FILL,0,32'h00777000,20'h00099,1,4'd0,3'b000,32'h0,0,0),
      vec(OP_LOOK,0,32'h00777FFF,20'h0,0,4'd8,3'b100,32'h00099FFF,1,0),   // R8
      vec(OP_LOOK,0,32'h00778000,20'h0,0,4'd2,3'b010,32'h0,0,0)           // R2
   };

   logic [36:0] obs;   // {hit, miss, fault, paddr, ref, dirty}

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", fails, checks);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic look(input logic [31:0] a, input logic wr);
      @(negedge clk);
      lk_valid = 1'b1; lk_write = wr; lk_vaddr = a;
      #1;
      obs = {lk_hit, lk_miss, lk_fault, lk_paddr, lk_ref, lk_dirty};
      @(posedge clk);
      #1;
      lk_valid = 1'b0; lk_write = 1'b0;
   endtask

   task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic pr);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_present = pr;
      @(posedge clk);
      #1;
      fill_en = 1'b0;
   endtask

   task automatic clear();
      @(negedge clk);
      clr_ref = 1'b1;
      @(posedge clk);
      #1;
      clr_ref = 1'b0;
   endtask

   // expected hit result for page v translating to ppn p, offset 0
   function automatic logic [36:0] hit_exp(input logic [19:0] p, input logic r, input logic d);
      return {3'b100, p, 12'h000, r, d};
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = TBL[i];
         case (v[96:95])
            OP_LOOK: begin
               look(v[93:62], v[94]);
               check($sformatf("R%0d vector %0d", v[40:37], i), 64'(obs),
                     64'({v[36:34], v[33:2], v[1], v[0]}));
            end
            OP_FILL: fill(v[93:74], v[61:42], v[41]);
            default: clear();
         endcase
      end

      // R2: idle lookup raises nothing
      @(negedge clk);
      lk_valid = 1'b0; lk_vaddr = 32'h12345000;
      #1;
      check("R2 idle", 64'({lk_hit, lk_miss, lk_fault}), 64'(3'b000));

      // R7: clear and hit in the same cycle
      @(negedge clk);
      clr_ref = 1'b1; lk_valid = 1'b1; lk_write = 1'b0; lk_vaddr = 32'h12345000;
      @(posedge clk);
      #1;
      clr_ref = 1'b0; lk_valid = 1'b0;
      look(32'h12345000, 1'b0);
      check("R7 same-cycle hit keeps ref", 64'(obs[1]), 64'(1'b1));
      look(32'h00777000, 1'b0);
      check("R7 other slot cleared", 64'(obs[1]), 64'(1'b0));

      // R4: reset empties the array
      do_reset();
      look(32'h12345000, 1'b0);
      check("R4 miss after reset", 64'(obs[36:34]), 64'(3'b010));

      // R9: sixteen fills land in empty slots, none displaced
      for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00A00 + 20'(i), 1'b1);
      for (int i = 0; i < 16; i++) begin
         look({20'h00100 + 20'(i), 12'h000}, 1'b0);
         check($sformatf("R9 slot page %0d", i), 64'(obs), 64'(hit_exp(20'h00A00 + 20'(i), 1'b1, 1'b0)));
      end

      // R11: all hot, pointer takes slot 0 then slot 1
      fill(20'h00200, 20'h00B00, 1'b1);
      look(32'h00100000, 1'b0);
      check("R11 pointer slot 0 evicted", 64'(obs[36:34]), 64'(3'b010));
      look(32'h00200000, 1'b0);
      check("R11 new page present", 64'(obs), 64'(hit_exp(20'h00B00, 1'b1, 1'b0)));
      fill(20'h00201, 20'h00B01, 1'b1);
      look(32'h00101000, 1'b0);
      check("R11 pointer advanced to slot 1", 64'(obs[36:34]), 64'(3'b010));
      look(32'h00102000, 1'b0);
      check("R11 slot 2 kept", 64'(obs[36:34]), 64'(3'b100));

      // R10: after clearing, the lowest unused slot is taken
      clear();
      look(32'h00105000, 1'b0);
      look(32'h00103000, 1'b0);
      fill(20'h00202, 20'h00B02, 1'b1);
      look(32'h00200000, 1'b0);
      check("R10 slot 0 unused taken", 64'(obs[36:34]), 64'(3'b010));
      look(32'h00202000, 1'b0);
      check("R10 new page present", 64'(obs), 64'(hit_exp(20'h00B02, 1'b1, 1'b0)));
      fill(20'h00203, 20'h00B03, 1'b1);
      look(32'h00201000, 1'b0);
      check("R10 slot 1 taken next", 64'(obs[36:34]), 64'(3'b010));
      fill(20'h00204, 20'h00B04, 1'b1);
      look(32'h00102000, 1'b0);
      check("R10 slot 2 taken next", 64'(obs[36:34]), 64'(3'b010));
      look(32'h00103000, 1'b0);
      check("R10 used slot 3 kept", 64'(obs[36:34]), 64'(3'b100));
      look(32'h00105000, 1'b0);
      check("R10 used slot 5 kept", 64'(obs[36:34]), 64'(3'b100));
      look(32'h00204000, 1'b0);
      check("R10 latest page present", 64'(obs), 64'(hit_exp(20'h00B04, 1'b1, 1'b0)));

      finish_run();
   end

endmodule